// File: doc/BRIEF.md
# XOR Registered Logic Macrocell

This block is one registered output cell of a fuse-programmed sum-of-products array. It is modelled as plain logic driven by a configuration vector. Four product terms are each formed from a connection mask over the true and complement columns of the cell's inputs and of its own stored bit. The terms are grouped into two OR sums, the sums are XORed, and the result is registered on the rising clock edge. Because of the XOR, one cell can be programmed as a counter stage that toggles when its carry input is HIGH.

The stored bit leaves the cell through an inverting output driver. A shared active-LOW enable pin gates that driver. For test, the register can be loaded straight from the pin value while the outputs are disabled. An active-LOW reset clears the register, so the pin reads HIGH after power-up.

Top module: `xor_macrocell`

## Requirements
- R1: A product term whose connection mask is all zero evaluates HIGH. Each term is the AND of the columns whose mask bit is 1. In `fuse_i`, term t occupies bits `[t*COLS +: COLS]`, where COLS = 2*(N_IN+1). Column 2k is line k and column 2k+1 is its complement. Lines 0..N_IN-1 are `in_i`, and line N_IN is the stored bit.
- R2: A product term connected to both the true and the complement column of the same line evaluates LOW whatever the inputs are.
- R3: On each rising clock edge with `preload` LOW, the register captures (term0 | term1) XOR (term2 | term3).
- R4: The feedback line N_IN carries the value the register holds before the edge, so a cell programmed as (q) XOR (in_i[0]) toggles on each edge where in_i[0] is 1 and holds otherwise.
- R5: `pad_o` is the inverse of the stored bit: a stored 1 reads as LOW.
- R6: While `rst_n` is LOW the register is cleared at once, so `pad_o` is HIGH on the first edge after reset is released.
- R7: `pad_en` is HIGH exactly when `oe_n` is LOW.
- R8: On a rising edge with `preload` HIGH and `oe_n` HIGH, the register loads `pad_i` and the array result is ignored. After a preload of 1 and re-enable, `pad_o` reads LOW.
- R9: On a rising edge with `preload` HIGH and `oe_n` LOW, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-LOW reset |
| in_i | input | N_IN | Array input lines |
| fuse_i | input | 4*COLS | Connection masks of the four product terms |
| oe_n | input | 1 | Shared active-LOW output enable |
| preload | input | 1 | Test preload mode |
| pad_i | input | 1 | Value driven onto the pin from outside during preload |
| pad_o | output | 1 | Inverted stored bit |
| pad_en | output | 1 | Output driver enable |

## Verification
The bench programs random connection masks, including all-zero terms and terms that join a line with its own complement. A wrong default would show a term that is LOW when it should be HIGH, or a conflicting term that still passes a pattern. The counter configuration catches feedback that is taken from D rather than from the stored bit, since that cell would not toggle cleanly. Preload is tried with the outputs disabled and with them enabled. A design that loads while enabled, or that lets the array win over a preload, would leave the wrong level on `pad_o`.

// File: rtl/xor_macrocell.sv
module xor_macrocell #(
  parameter  int N_IN = 4,
  localparam int COLS = 2 * (N_IN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_i,
  input  logic [4*COLS-1:0] fuse_i,
  input  logic              oe_n,
  input  logic              preload,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_en
);

  logic            q;
  logic [N_IN:0]   line;
  logic [COLS-1:0] col;
  logic [3:0]      pterm;
  logic            d;

  assign line = {q, in_i};

  for (genvar k = 0; k <= N_IN; k++) begin : g_col
    assign col[2*k]   = line[k];
    assign col[2*k+1] = ~line[k];
  end

  for (genvar t = 0; t < 4; t++) begin : g_term
    assign pterm[t] = &(~fuse_i[t*COLS +: COLS] | col);
  end

  assign d = (pterm[0] | pterm[1]) ^ (pterm[2] | pterm[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (preload) begin
      if (oe_n)       q <= pad_i;
    end
    else              q <= d;
  end

  assign pad_o  = ~q;
  assign pad_en = ~oe_n;

endmodule

module xor_macrocell_chk (
  input logic clk,
  input logic rst_n,
  input logic oe_n,
  input logic preload,
  input logic pad_i,
  input logic pad_o,
  input logic pad_en
);

  AST_RESET_PIN_HIGH: assert property (@(posedge clk) $rose(rst_n) |-> pad_o); // R6

  AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && oe_n) |=> (pad_o == !$past(pad_i))); // R8

  AST_PRELOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !oe_n) |=> $stable(pad_o)); // R9

  AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_en) |-> !$stable(oe_n)); // R7

endmodule

bind xor_macrocell xor_macrocell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .preload(preload),
  .pad_i(pad_i), .pad_o(pad_o), .pad_en(pad_en)
);

// File: tb/xor_macrocell_tb.sv
module xor_macrocell_tb;
  localparam int N_IN = 4;
  localparam int COLS = 2 * (N_IN + 1);

  logic clk = 0, rst_n = 0;
  logic [N_IN-1:0]   in_i = '0;
  logic [4*COLS-1:0] fuse_i = '0;
  logic oe_n = 1, preload = 0, pad_i = 0;
  logic pad_o, pad_en;
  logic q_m;
  int checks = 0, errors = 0;
  bit done = 0;

  xor_macrocell #(.N_IN(N_IN)) u_dut (.*);

  always #2 clk = ~clk;

  function automatic logic term_val(input logic [COLS-1:0] m,
                                    input logic [N_IN-1:0] x, input logic q);
    logic [N_IN:0] ln = {q, x};
    for (int c = 0; c < COLS; c++)
      if (m[c] && ((c % 2 == 0) ? !ln[c/2] : ln[c/2])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic next_d(input logic [4*COLS-1:0] f,
                                  input logic [N_IN-1:0] x, input logic q);
    logic [3:0] p;
    for (int t = 0; t < 4; t++) p[t] = term_val(f[t*COLS +: COLS], x, q);
    return (p[0] | p[1]) ^ (p[2] | p[3]);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic nq;
    if (preload) nq = oe_n ? pad_i : q_m;
    else         nq = next_d(fuse_i, in_i, q_m);
    @(posedge clk); @(negedge clk);
    q_m = nq;
    check(req, pad_o, ~q_m);
    check("R7", pad_en, ~oe_n);
  endtask

  function automatic logic [COLS-1:0] one_col(input int c);
    logic [COLS-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    #400000;
    $display("FAIL watchdog actual=timeout expected=finish");
    errors++;
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    check("R6", pad_o, 1'b1);
    rst_n = 1; q_m = 0;
    oe_n = 0;
    @(negedge clk);
    check("R6", pad_o, 1'b1);

    // R1: all terms empty -> (1|1)^(1|1) = 0 ; term0 only empty -> 1
    fuse_i = '0;
    in_i = 4'hA; step("R1");
    check("R1", pad_o, 1'b1);
    fuse_i = {3{one_col(0) | one_col(1)}} << COLS;
    in_i = 4'h5; step("R1");
    check("R1", pad_o, 1'b0);

    // R2: every term conflicting on line 1 -> D = 0
    fuse_i = {4{one_col(2) | one_col(3) | one_col(4)}};
    for (int i = 0; i < 4; i++) begin in_i = 4'($urandom); step("R2"); end
    check("R2", pad_o, 1'b1);

    // R4: counter bit, sums q and in_i[0]
    fuse_i = {one_col(0), one_col(0), one_col(2*N_IN), one_col(2*N_IN)};
    in_i = 4'h1;
    for (int i = 0; i < 6; i++) begin
      step("R4");
      check("R4", pad_o, (i % 2 == 0) ? 1'b0 : 1'b1);
    end
    in_i = 4'h0;
    for (int i = 0; i < 3; i++) step("R4");

    // R8: preload with outputs disabled overrides the counter
    oe_n = 1; preload = 1;
    pad_i = 1; step("R8");
    pad_i = 0; step("R8");
    pad_i = 1; step("R8");
    preload = 0; pad_i = 0; in_i = 4'h0; oe_n = 0;
    step("R8");
    check("R8", pad_o, 1'b0);

    // R9: preload while enabled keeps the register
    preload = 1; pad_i = 0; in_i = 4'h1;
    step("R9"); step("R9");
    check("R9", pad_o, 1'b0);
    preload = 0;

    // R3/R5: random masks and inputs
    for (int i = 0; i < 300; i++) begin
      for (int t = 0; t < 4; t++)
        fuse_i[t*COLS +: COLS] = COLS'($urandom) & COLS'($urandom);
      in_i = 4'($urandom);
      oe_n = 1'($urandom);
      step("R3");
    end

    // R6: reset mid-run clears at once
    fuse_i = '0; fuse_i[0 +: COLS] = one_col(2*N_IN+1);
    step("R5");
    @(posedge clk); #1 rst_n = 0; #1;
    check("R6", pad_o, 1'b1);
    @(negedge clk); rst_n = 1; q_m = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule